// File: doc/BRIEF.md
# Snapshot position byte reader

This block sits between a free-running 16-bit position counter and a narrow 8-bit read port. On every rising clock edge it copies the count into a holding register, called the snapshot. A reader fetches the snapshot as two bytes, the upper byte first and then the lower byte. It uses an active-low output enable and a byte-select input to do so.

The enable and select levels are sampled on the falling clock edge. A small inhibit state machine watches these samples. Once an upper-byte read is seen, the snapshot stops following the counter. It stays frozen until a lower-byte read has been seen and the enable has then been sampled inactive. The counter outside keeps running the whole time. The two bytes of one read therefore always belong to the same count, and no counts are lost.

A width parameter allows a narrower position of 9 to 16 bits. The unused upper bits of the high byte then read as zero.

Top module: `pos_readout`

## Requirements
- R1: While `oe_n` is 1, `dout_en` is 0 and `dout` is 0. While `oe_n` is 0, `dout_en` is 1.
- R2: With `oe_n` at 0 and `sel` at 0, `dout` shows snapshot bits 15..8 (the upper byte).
- R3: With `oe_n` at 0 and `sel` at 1, `dout` shows snapshot bits 7..0 (the lower byte).
- R4: While no read is in progress, the snapshot loads `count` on every rising edge.
- R5: A falling-edge sample of `oe_n`=0 with `sel`=0 freezes the snapshot from the next rising edge. It stays frozen while the counter advances.
- R6: The freeze ends on the first rising edge after two events, in this order: a falling-edge sample of `oe_n`=0 with `sel`=1, then a falling-edge sample of `oe_n`=1. That rising edge loads `count` again.
- R7: An upper-byte read followed by a lower-byte read returns two halves of the same count, even while `count` changes between the two reads.
- R8: While `rst_n` is 0 at a rising edge, the snapshot is cleared to 0 and the freeze is released. The sampled enable is treated as inactive at each falling edge during reset.
- R9: With `POS_W` below 16, `dout` bits 7..(`POS_W`-8) read 0 during an upper-byte read. The remaining low bits carry snapshot bits `POS_W`-1..8.
- R10: A lower-byte read that follows no upper-byte read does not freeze the snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Enable and select are sampled on its falling edge; the snapshot updates on its rising edge. |
| rst_n | input | 1 | Synchronous reset, active low |
| count | input | POS_W | Running position count from the counter |
| oe_n | input | 1 | Output enable, active low |
| sel | input | 1 | Byte select: 0 selects the upper byte, 1 the lower byte |
| dout | output | 8 | Read data byte, 0 while not enabled |
| dout_en | output | 1 | Drive enable for an external tri-state pad |

## Verification
The assertions assume three things about the inputs:
- `oe_n` and `sel` are settled around each falling edge.
- `count` is settled around each rising edge.
- Reset is held across at least one falling edge and one rising edge, so that the sampled levels are defined before any check is armed.

The bench changes every input one nanosecond after a rising edge, which keeps all inputs away from both edges. It asserts reset for several full cycles. Its reference model mirrors those same edge rules: it samples enable and select at the falling edge and updates the snapshot at the rising edge.

// File: rtl/pos_rd_pkg.sv
// Shared types for the snapshot byte reader.
package pos_rd_pkg;
    localparam int BYTE_W = 8;

    // Inhibit state: tracking the counter, frozen after upper-byte read,
    // frozen with the lower byte already read.
    typedef enum logic [1:0] {
        RD_TRACK    = 2'd0,
        RD_HELD     = 2'd1,
        RD_LOW_DONE = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pos_rd_sampler.sv
// Samples the read-control pins on the falling clock edge.
// Assumes oe_n and sel are settled around the falling edge.
// Reset (synchronous, active low) forces an inactive sampled enable.
module pos_rd_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic sel,
    output logic smp_oe_n,
    output logic smp_sel
);
    // Capture enable and select on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            smp_oe_n <= 1'b1;
            smp_sel  <= 1'b0;
        end else begin
            smp_oe_n <= oe_n;
            smp_sel  <= sel;
        end
    end
endmodule

// File: rtl/pos_rd_inhibit.sv
// Inhibit state machine. Freezes the snapshot after an upper-byte read
// and releases it once a lower-byte read has been followed by an
// inactive enable. Works on the falling-edge samples; updates on the
// rising edge. load_en tells the snapshot register to load at this edge.
module pos_rd_inhibit
    import pos_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_oe_n,
    input  logic      smp_sel,
    output rd_state_e state,
    output logic      load_en
);
    rd_state_e state_nx;
    logic      hi_rd;
    logic      lo_rd;

    // Decode the sampled read kind.
    always_comb begin
        hi_rd = !smp_oe_n && !smp_sel;
        lo_rd = !smp_oe_n &&  smp_sel;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            RD_TRACK:    if (hi_rd) state_nx = RD_HELD;
            RD_HELD:     if (lo_rd) state_nx = RD_LOW_DONE;
            RD_LOW_DONE: begin
                if (smp_oe_n)   state_nx = RD_TRACK;
                else if (hi_rd) state_nx = RD_HELD;
            end
            default:     state_nx = RD_TRACK;
        endcase
    end

    // Load whenever the machine will be tracking after this edge.
    always_comb load_en = (state_nx == RD_TRACK);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_TRACK;
        else        state <= state_nx;
    end
endmodule

// File: rtl/pos_rd_latch.sv
// Snapshot register holding the position value presented for reading.
// Assumes count is settled around the rising edge.
module pos_rd_latch #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [POS_W-1:0] count,
    output logic [POS_W-1:0] pos_q
);
    // Load the count when allowed; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (load_en) pos_q <= count;
    end
endmodule

// File: rtl/pos_rd_bytemux.sv
// Byte multiplexer from the snapshot to the 8-bit port. Upper bits of a
// narrow snapshot are zero-filled. Output is 0 while not enabled.
module pos_rd_bytemux
    import pos_rd_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic [POS_W-1:0]  pos_q,
    input  logic              oe_n,
    input  logic              sel,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en
);
    localparam int HI_W = POS_W - BYTE_W;

    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;

    // Build the upper byte, zero-filling when the snapshot is narrow.
    generate
        if (HI_W < BYTE_W) begin : g_narrow
            always_comb hi_byte = {{(BYTE_W-HI_W){1'b0}}, pos_q[POS_W-1:BYTE_W]};
        end else begin : g_full
            always_comb hi_byte = pos_q[POS_W-1:BYTE_W];
        end
    endgenerate

    // Lower byte straight from the snapshot.
    always_comb lo_byte = pos_q[BYTE_W-1:0];

    // Select the byte and gate the port with the enable.
    always_comb begin
        dout_en = !oe_n;
        if (oe_n)     dout = '0;
        else if (sel) dout = lo_byte;
        else          dout = hi_byte;
    end
endmodule

// File: rtl/pos_readout.sv
// Top of the snapshot byte reader: falling-edge sampler, inhibit state
// machine, snapshot register and byte multiplexer.
// Assumes 9 <= POS_W <= 16 and a synchronous active-low reset.
module pos_readout
    import pos_rd_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  count,
    input  logic              oe_n,
    input  logic              sel,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en
);
    logic             smp_oe_n;
    logic             smp_sel;
    logic             load_en;
    rd_state_e        state;
    logic [POS_W-1:0] pos_q;

    pos_rd_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .sel      (sel),
        .smp_oe_n (smp_oe_n),
        .smp_sel  (smp_sel)
    );

    pos_rd_inhibit u_inh (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_oe_n (smp_oe_n),
        .smp_sel  (smp_sel),
        .state    (state),
        .load_en  (load_en)
    );

    pos_rd_latch #(.POS_W(POS_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .count   (count),
        .pos_q   (pos_q)
    );

    pos_rd_bytemux #(.POS_W(POS_W)) u_mux (
        .pos_q   (pos_q),
        .oe_n    (oe_n),
        .sel     (sel),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/pos_readout_chk.sv
// Property checker for pos_readout, attached with bind below.
module pos_readout_chk
    import pos_rd_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              sel,
    input  logic              smp_oe_n,
    input  logic              smp_sel,
    input  rd_state_e         state,
    input  logic [POS_W-1:0]  count,
    input  logic [POS_W-1:0]  pos_q,
    input  logic [BYTE_W-1:0] dout,
    input  logic              dout_en
);
    localparam int HI_W = POS_W - BYTE_W;

    a_r1_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dout_en && dout == '0));

    a_r4_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_TRACK && !(!smp_oe_n && !smp_sel)) |=> pos_q == $past(count));

    a_r5_freeze_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_oe_n && !smp_sel) |=> $stable(pos_q));

    a_r6_release_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_LOW_DONE && smp_oe_n) |=> (state == RD_TRACK && pos_q == $past(count)));

    a_r10_low_only_no_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_TRACK && !smp_oe_n && smp_sel) |=> state == RD_TRACK);

    generate
        if (HI_W < BYTE_W) begin : g_r9
            a_r9_high_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
                (!oe_n && !sel) |-> dout[BYTE_W-1:HI_W] == '0);
        end
    endgenerate
endmodule

bind pos_readout pos_readout_chk #(.POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .sel      (sel),
    .smp_oe_n (smp_oe_n),
    .smp_sel  (smp_sel),
    .state    (state),
    .count    (count),
    .pos_q    (pos_q),
    .dout     (dout),
    .dout_en  (dout_en)
);

// File: tb/tb_pos_readout.sv
`timescale 1ns/100ps
module tb_pos_readout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h0;
    logic        oe_n = 1'b1;
    logic        sel = 1'b0;
    logic [7:0]  dout, dout12;
    logic        dout_en, dout_en12;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference state
    int m_smp_oe = 1, m_smp_sel = 0;
    int m_inhib = 0, m_lowseen = 0;
    int m_lat = 0;

    always #2.5 clk = ~clk;

    pos_readout #(.POS_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .count(cnt), .oe_n(oe_n), .sel(sel),
        .dout(dout), .dout_en(dout_en));

    pos_readout #(.POS_W(12)) dut12 (
        .clk(clk), .rst_n(rst_n), .count(cnt[11:0]), .oe_n(oe_n), .sel(sel),
        .dout(dout12), .dout_en(dout_en12));

    // Model: falling-edge sampling
    always @(negedge clk) begin
        if (!rst_n) begin m_smp_oe = 1; m_smp_sel = 0; end
        else begin m_smp_oe = oe_n; m_smp_sel = sel; end
    end

    // Model: rising-edge inhibit and snapshot
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_inhib = 0; m_lowseen = 0;
        end else begin
            if (m_smp_oe == 0 && m_smp_sel == 0) begin m_inhib = 1; m_lowseen = 0; end
            else if (m_smp_oe == 0 && m_smp_sel == 1 && m_inhib == 1) m_lowseen = 1;
            else if (m_smp_oe == 1 && m_lowseen == 1) begin m_inhib = 0; m_lowseen = 0; end
            if (m_inhib == 0) m_lat = int'(cnt);
        end
    end

    function automatic int exp_byte(int lat, int w);
        if (oe_n) return 0;
        if (sel) return lat & 255;
        return (lat >> 8) & ((1 << (w - 8)) - 1);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare both instances to the model after a rising edge
    task automatic cmp_model();
        string tag;
        int e16, e12;
        tag = oe_n ? "R1" : (sel ? "R3" : "R2");
        e16 = exp_byte(m_lat, 16);
        e12 = exp_byte(m_lat & 16'hFFF, 12);
        chk(dout == e16[7:0] && dout_en == !oe_n, tag, {dout_en, dout}, {!oe_n, e16[7:0]});
        chk(dout12 == e12[7:0] && dout_en12 == !oe_n,
            (!oe_n && !sel) ? "R9" : tag, {dout_en12, dout12}, {!oe_n, e12[7:0]});
    endtask

    // One cycle: drive at rising+1ns, compare at next rising+0.5ns
    task automatic step(bit o, bit s, int inc);
        oe_n = o; sel = s; cnt = cnt + 16'(inc);
        @(posedge clk); #0.5;
        cmp_model();
        #0.5;
    endtask

    initial begin
        logic [15:0] snap;
        // Reset with a high-byte read pending: R8
        oe_n = 0; sel = 0; cnt = 16'h1234;
        repeat (4) begin @(posedge clk); #0.5; cmp_model(); #0.5; end
        chk(dout == 8'h00, "R8 cleared during reset", dout, 0);
        oe_n = 1;
        @(posedge clk); #1;
        rst_n = 1;
        // Idle tracking
        repeat (5) step(1, 0, 7);
        // Low reads without a prior high read keep tracking: R4, R10
        for (int i = 0; i < 6; i++) begin
            step(0, 1, 3);
            if (i > 0) chk(dout == cnt[7:0], "R4/R10 low read tracks", dout, cnt[7:0]);
        end
        step(1, 0, 1);
        // Coherent read: R5, R6, R7
        cnt = 16'hF0FE;
        step(1, 0, 0);
        snap = cnt;
        step(0, 0, 5);
        chk(dout == snap[15:8], "R2 high byte", dout, snap[15:8]);
        chk(dout12 == {4'h0, snap[11:8]}, "R9 narrow high byte", dout12, {4'h0, snap[11:8]});
        repeat (4) step(1, 0, 16'h0101);
        step(0, 0, 3);
        chk(dout == snap[15:8], "R5 frozen high byte", dout, snap[15:8]);
        step(1, 1, 9);
        step(0, 1, 9);
        chk(dout == snap[7:0], "R7 low byte same snapshot", dout, snap[7:0]);
        step(1, 0, 2);
        step(0, 1, 4);
        chk(dout == cnt[7:0], "R6 released and reloading", dout, cnt[7:0]);
        step(1, 0, 1);
        // Mixed patterns compared to model every cycle
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 7));
            step(r[2] & r[1], r[0], int'($urandom_range(0, 300)));
        end
        // Reset in the middle of a frozen read: R8
        step(0, 0, 1);
        rst_n = 0;
        step(1, 0, 1);
        chk(dout == 8'h00, "R8 port quiet", dout, 0);
        rst_n = 1;
        step(0, 1, 1);
        chk(dout == cnt[7:0], "R8 inhibit released by reset", dout, cnt[7:0]);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule